// File: doc/BRIEF.md
# Readback State Capture Controller

This block decides when the registered outputs of user logic are copied into a capture shadow, and then serialises that shadow as a readback frame. It takes a frame-start strobe, an active-low user capture request, a 2-bit policy setting and the live register vector. A capture copies the whole live vector into the shadow on a rising clock edge and raises a one-cycle capture pulse. An accepted start strobe begins a frame that shifts the shadow out one bit per cycle, least significant bit first.

Each frame bit is compared with a golden frame. A used-position mask clears the bits that configuration leaves unused before the comparison. The policy setting selects one of four capture sources: never, on frame start, on the user request, or on either of the two. While a frame is being shifted, every capture source and every further start strobe is blocked. This keeps the shifted data coherent. With no capture, the frame reproduces the shadow's default contents, which are the configured initial values (zero by default). Those bits therefore match the configuration data bit for bit.

Top module: `rb_capture_ctrl`

## Requirements
- R1: After synchronous reset the shadow holds the default value (all zeros by default), and `cap_pulse`, `rb_valid`, `rb_bit`, `rb_masked` and `rb_miss` are 0.
- R2: With `mode` = 0 the shadow never changes, whatever `rb_start`, `cap_req_n` and `live_q` do. A frame started in this mode shifts out the default contents.
- R3: With `mode` = 1 the shadow loads `live_q` on the edge where an idle block samples `rb_start` high. `cap_req_n` has no effect in this mode.
- R4: With `mode` = 2 the shadow loads `live_q` on every edge where an idle block samples `cap_req_n` low. Holding it low gives continuous capture. `rb_start` alone captures nothing.
- R5: With `mode` = 3 the shadow loads `live_q` on an edge where an idle block sees either `rb_start` high or `cap_req_n` low.
- R6: `cap_pulse` is high for exactly the one cycle following each capture edge and low otherwise.
- R7: An accepted `rb_start` makes `rb_valid` high for exactly W cycles starting the cycle after that edge. In the k-th of these cycles (k from 0), `rb_bit` equals shadow bit k.
- R8: While a frame is being shifted, no capture takes place and `rb_start` is ignored. The frame still ends after W cycles.
- R9: `rb_masked` equals `rb_bit` where `used_mask` bit k is 1, and is 0 where it is 0 or where no frame is active.
- R10: `rb_miss` is high in frame cycle k exactly when `used_mask` bit k is 1 and `rb_bit` differs from `golden` bit k. It is 0 outside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Capture policy: 0 none, 1 start, 2 user request, 3 either |
| rb_start | input | 1 | Frame-start strobe |
| cap_req_n | input | 1 | Active-low user capture request |
| live_q | input | W | Live register outputs |
| golden | input | W | Expected frame bits |
| used_mask | input | W | 1 marks a frame position that is compared |
| cap_pulse | output | 1 | One-cycle pulse after a capture |
| shadow_q | output | W | Captured vector |
| rb_valid | output | 1 | Frame bit valid |
| rb_bit | output | 1 | Serial frame bit, LSB first |
| rb_masked | output | 1 | Frame bit with unused positions cleared |
| rb_miss | output | 1 | Unmasked frame bit differs from golden |

## Verification
A capture sampled at edge N shows in `shadow_q` and `cap_pulse` one cycle later. The bench drives inputs on the falling edge and checks at the next falling edge. Frame bit 0 appears in that same sample window. Bit k is due k falling edges later, and `rb_valid` must be low at the (W)th falling edge after the start. The bench follows that schedule, with expected shadow contents kept in its own model from the policy rules.

// File: rtl/rbcap_pkg.sv
package rbcap_pkg;

    typedef enum logic [1:0] {
        CAP_NONE     = 2'd0,
        CAP_ON_START = 2'd1,
        CAP_ON_USER  = 2'd2,
        CAP_EITHER   = 2'd3
    } cap_mode_e;

    // bit 0 of the policy enables the start source, bit 1 the user source
    function automatic logic uses_start(cap_mode_e m);
        return m[0];
    endfunction

    function automatic logic uses_user(cap_mode_e m);
        return m[1];
    endfunction

    typedef struct packed {
        logic valid;
        logic data;
        logic masked;
        logic miss;
    } rb_beat_t;

endpackage

// File: rtl/rbcap_policy.sv
module rbcap_policy
    import rbcap_pkg::*;
(
    input  cap_mode_e mode,
    input  logic      rb_start,
    input  logic      cap_req_n,
    input  logic      busy,
    output logic      cap_en
);
    logic start_hit;
    logic user_hit;

    always_comb begin
        start_hit = uses_start(mode) && rb_start;
        user_hit  = uses_user(mode) && !cap_req_n;
        cap_en    = !busy && (start_hit || user_hit);
    end
endmodule

// File: rtl/rbcap_shadow.sv
module rbcap_shadow #(
    parameter int          W    = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_en,
    input  logic [W-1:0] live_q,
    output logic [W-1:0] shadow,
    output logic         cap_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow    <= INIT;
            cap_pulse <= 1'b0;
        end else begin
            cap_pulse <= cap_en;
            if (cap_en) shadow <= live_q;
        end
    end

    a_r6_pulse_follows: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> cap_pulse);
    a_r6_pulse_only: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> !cap_pulse);
endmodule

// File: rtl/rbcap_shifter.sv
module rbcap_shifter
    import rbcap_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rb_start,
    input  logic [W-1:0] shadow,
    input  logic [W-1:0] golden,
    input  logic [W-1:0] used_mask,
    output logic         busy,
    output rb_beat_t     beat
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [IW-1:0] LAST = IW'(W - 1);

    logic [IW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (!busy) begin
            if (rb_start) begin
                busy <= 1'b1;
                idx  <= '0;
            end
        end else if (idx == LAST) begin
            busy <= 1'b0;
            idx  <= '0;
        end else begin
            idx <= idx + IW'(1);
        end
    end

    logic cur_bit, cur_used, cur_gold;

    always_comb begin
        cur_bit     = shadow[idx];
        cur_used    = used_mask[idx];
        cur_gold    = golden[idx];
        beat.valid  = busy;
        beat.data   = busy && cur_bit;
        beat.masked = busy && cur_used && cur_bit;
        beat.miss   = busy && cur_used && (cur_bit != cur_gold);
    end

    a_r7_advance: assert property (@(posedge clk) disable iff (rst)
        (busy && idx != LAST) |=> (busy && idx == $past(idx) + IW'(1)));
    a_r7_frame_end: assert property (@(posedge clk) disable iff (rst)
        (busy && idx == LAST) |=> !busy);
    a_r7_start_idx: assert property (@(posedge clk) disable iff (rst)
        (!busy && rb_start) |=> (busy && idx == '0));
    a_r10_miss_in_frame: assert property (@(posedge clk) disable iff (rst)
        beat.miss |-> beat.valid);
    a_r9_masked_in_frame: assert property (@(posedge clk) disable iff (rst)
        beat.masked |-> (beat.valid && beat.data));
endmodule

// File: rtl/rb_capture_ctrl.sv
module rb_capture_ctrl
    import rbcap_pkg::*;
#(
    parameter int           W    = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode,
    input  logic         rb_start,
    input  logic         cap_req_n,
    input  logic [W-1:0] live_q,
    input  logic [W-1:0] golden,
    input  logic [W-1:0] used_mask,
    output logic         cap_pulse,
    output logic [W-1:0] shadow_q,
    output logic         rb_valid,
    output logic         rb_bit,
    output logic         rb_masked,
    output logic         rb_miss
);
    cap_mode_e mode_e;
    logic      busy;
    logic      cap_en;
    rb_beat_t  beat;

    assign mode_e = cap_mode_e'(mode);

    rbcap_policy u_policy (
        .mode      (mode_e),
        .rb_start  (rb_start),
        .cap_req_n (cap_req_n),
        .busy      (busy),
        .cap_en    (cap_en)
    );

    rbcap_shadow #(.W(W), .INIT(INIT)) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .live_q    (live_q),
        .shadow    (shadow_q),
        .cap_pulse (cap_pulse)
    );

    rbcap_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .rb_start  (rb_start),
        .shadow    (shadow_q),
        .golden    (golden),
        .used_mask (used_mask),
        .busy      (busy),
        .beat      (beat)
    );

    assign rb_valid  = beat.valid;
    assign rb_bit    = beat.data;
    assign rb_masked = beat.masked;
    assign rb_miss   = beat.miss;

    a_r8_hold_in_frame: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(shadow_q));
    a_r2_none_holds: assert property (@(posedge clk) disable iff (rst)
        (mode_e == CAP_NONE) |=> $stable(shadow_q));
    a_r3_start_captures: assert property (@(posedge clk) disable iff (rst)
        (mode_e == CAP_ON_START && rb_start && !busy) |=> (cap_pulse && shadow_q == $past(live_q)));
    a_r4_user_captures: assert property (@(posedge clk) disable iff (rst)
        (mode_e == CAP_ON_USER && !cap_req_n && !busy) |=> (shadow_q == $past(live_q)));
endmodule

// File: tb/tb_rb_capture_ctrl.sv
`timescale 1ns/1ps
module tb_rb_capture_ctrl;
    localparam int W = 8;
    localparam logic [W-1:0] GOLD = 8'hA5;
    localparam logic [W-1:0] MASK = 8'h7E;

    logic clk = 1'b0;
    logic rst;
    logic [1:0] mode;
    logic rb_start, cap_req_n;
    logic [W-1:0] live_q;
    logic cap_pulse, rb_valid, rb_bit, rb_masked, rb_miss;
    logic [W-1:0] shadow_q;

    always #10 clk = ~clk;

    rb_capture_ctrl #(.W(W)) dut (
        .clk(clk), .rst(rst), .mode(mode), .rb_start(rb_start),
        .cap_req_n(cap_req_n), .live_q(live_q), .golden(GOLD),
        .used_mask(MASK), .cap_pulse(cap_pulse), .shadow_q(shadow_q),
        .rb_valid(rb_valid), .rb_bit(rb_bit), .rb_masked(rb_masked),
        .rb_miss(rb_miss)
    );

    int checks = 0;
    int fails  = 0;
    bit reported = 0;
    logic [W-1:0] exp_sh;

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
        $finish;
    endtask

    task automatic quiet();
        rb_start  = 1'b0;
        cap_req_n = 1'b1;
    endtask

    // called at the falling edge right after the start edge; inputs already quiet
    task automatic run_frame(input logic [W-1:0] e, input bit disturb);
        for (int k = 0; k < W; k++) begin
            chk(rb_valid == 1'b1, "R7 valid", rb_valid, 1);
            chk(rb_bit == e[k], "R7 bit", rb_bit, e[k]);
            chk(rb_masked == (e[k] & MASK[k]), "R9 masked", rb_masked, e[k] & MASK[k]);
            chk(rb_miss == (MASK[k] & (e[k] ^ GOLD[k])), "R10 miss", rb_miss,
                MASK[k] & (e[k] ^ GOLD[k]));
            if (disturb && k < W - 1) begin
                rb_start = 1'b1; cap_req_n = 1'b0; live_q = ~live_q;
            end else begin
                quiet();
            end
            @(negedge clk);
            if (disturb) chk(shadow_q == e, "R8 shadow held", shadow_q, e);
        end
        chk(rb_valid == 1'b0, "R7 frame length", rb_valid, 0);
        chk(rb_miss == 1'b0 && rb_masked == 1'b0, "R10 idle outputs", {rb_miss, rb_masked}, 0);
    endtask

    // {mode[1:0], start, req_n, live[7:0], expect_capture}
    localparam int NV = 9;
    localparam logic [12:0] VEC [NV] = '{
        {2'd0, 1'b1, 1'b0, 8'h3C, 1'b0},  // R2: nothing captured, frame = default
        {2'd1, 1'b0, 1'b0, 8'h11, 1'b0},  // R3: request ignored
        {2'd1, 1'b1, 1'b1, 8'h5A, 1'b1},  // R3: start captures
        {2'd2, 1'b0, 1'b1, 8'hFF, 1'b0},  // R4: no request
        {2'd2, 1'b0, 1'b0, 8'hC3, 1'b1},  // R4: request low captures
        {2'd2, 1'b1, 1'b1, 8'h0F, 1'b0},  // R4: start alone does not capture
        {2'd3, 1'b0, 1'b0, 8'h96, 1'b1},  // R5: request source
        {2'd3, 1'b1, 1'b1, 8'hA5, 1'b1},  // R5: start source, frame equals golden
        {2'd0, 1'b0, 1'b0, 8'h77, 1'b0}   // R2: request ignored
    };

    initial begin
        rst = 1'b1; mode = 2'd0; live_q = '0; quiet();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(shadow_q == '0, "R1 shadow", shadow_q, 0);
        chk(cap_pulse == 1'b0, "R1 cap_pulse", cap_pulse, 0);
        chk(rb_valid == 1'b0 && rb_bit == 1'b0, "R1 frame idle", {rb_valid, rb_bit}, 0);
        chk(rb_masked == 1'b0 && rb_miss == 1'b0, "R1 compare idle", {rb_masked, rb_miss}, 0);
        exp_sh = '0;

        for (int v = 0; v < NV; v++) begin
            logic [12:0] e;
            e = VEC[v];
            mode = e[12:11]; rb_start = e[10]; cap_req_n = e[9]; live_q = e[8:1];
            @(negedge clk);
            quiet();
            if (e[0]) exp_sh = e[8:1];
            chk(cap_pulse == e[0], "R6 cap_pulse", cap_pulse, e[0]);
            chk(shadow_q == exp_sh, "R2/R3/R4/R5 shadow", shadow_q, exp_sh);
            if (e[10]) run_frame(exp_sh, 0);
            else begin
                @(negedge clk);
                chk(cap_pulse == 1'b0, "R6 single pulse", cap_pulse, 0);
            end
        end

        // R4: continuous capture while request held low
        mode = 2'd2; cap_req_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            live_q = 8'h21 * (i + 1);
            @(negedge clk);
            chk(shadow_q == 8'h21 * (i + 1), "R4 continuous", shadow_q, 8'h21 * (i + 1));
            chk(cap_pulse == 1'b1, "R6 continuous pulse", cap_pulse, 1);
        end
        quiet();
        exp_sh = 8'h84;

        // R8: captures and restarts blocked during a frame
        mode = 2'd3; live_q = 8'h6D; rb_start = 1'b1;
        @(negedge clk);
        quiet();
        exp_sh = 8'h6D;
        chk(shadow_q == exp_sh, "R5 start capture", shadow_q, exp_sh);
        run_frame(exp_sh, 1);
        chk(cap_pulse == 1'b0, "R8 no capture in frame", cap_pulse, 0);

        // R1: reset during a frame
        mode = 2'd1; live_q = 8'hF0; rb_start = 1'b1;
        @(negedge clk);
        quiet();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(rb_valid == 1'b0, "R1 reset mid-frame", rb_valid, 0);
        chk(shadow_q == '0, "R1 shadow after reset", shadow_q, 0);

        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        summary();
    end
endmodule